// File: doc/BRIEF.md
# Interrupt Source Gateway Bank

This block sits in front of the priority logic of a platform-level interrupt controller. It holds one gateway for each of a parameterised number of interrupt sources. Each gateway watches its raw request line. A per-source mode bit sets how it watches: it can look for rising edges, or it can follow the line while the line is high. When a gateway sees a qualifying event, it raises that source's pending bit.

A target takes an interrupt by issuing a claim that carries the source's identifier. Source i uses identifier i+1, and identifier 0 means "no interrupt". A claim moves the source from pending to in service. From the moment a source becomes pending until the target issues a matching complete, its gateway is locked. Any request seen in that window is dropped, and missed edges are not counted. A complete reopens the gateway. A level source whose line is still high then becomes pending again one cycle later.

The block drives the pending vector and the in-service vector. The priority selector and the target logic downstream use them.

Top module: `irq_gateway_bank`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears every pending bit, every in-service bit and every stored previous-input sample.
- R2: With edge_mode_i[i]=1 (edge mode), a 0-to-1 change of src_i[i] between two consecutive clock edges sets pending_o[i] at the second edge. A line that stays high does not raise it again.
- R3: With edge_mode_i[i]=0 (level mode), src_i[i] high at a clock edge sets pending_o[i] at that edge, if the gateway is not locked.
- R4: A claim (claim_valid_i=1, claim_id_i=i+1) for a pending source clears pending_o[i] and sets in_service_o[i] at the next edge. A claim for a source that is not pending changes nothing.
- R5: While pending_o[i] or in_service_o[i] is set, requests on src_i[i] are discarded. This includes an event in the same cycle as the claim. Nothing is remembered, so no interrupt follows from them later.
- R6: A complete (complete_valid_i=1, complete_id_i=i+1) for an in-service source clears in_service_o[i] at the next edge. A level-mode source still high becomes pending at the edge after that.
- R7: In edge mode, an edge that arrived while locked does not fire after the complete. The previous-input sample keeps following the line while the gateway is locked.
- R8: A claim or complete with identifier 0, or with an identifier above NSRC, is ignored. A complete for a source that is not in service is ignored.
- R9: pending_o[i] and in_service_o[i] are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Raw interrupt request lines |
| edge_mode_i | input | NSRC | Per-source mode: 1 edge, 0 level |
| claim_valid_i | input | 1 | Claim event strobe |
| claim_id_i | input | IDW | Identifier of the claimed source (source i is i+1) |
| complete_valid_i | input | 1 | Complete event strobe |
| complete_id_i | input | IDW | Identifier of the completed source |
| pending_o | output | NSRC | Pending bit per source |
| in_service_o | output | NSRC | In-service bit per source |

## Verification
The bench sends a single rising edge, and then a line held high, to an edge-mode source. This shows that the edge fires once and a steady line does not fire again. The level-mode source gets the same held line, with a complete issued while the line is still high. This separates re-arming on level from re-arming on edge. A pulse that falls and rises again during the in-service window tells a gateway that drops events apart from one that stores them. Claims and completes with identifier 0, an out-of-range identifier, a non-pending source and a non-in-service source each check that the target side only acts on sources in the right state.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

   // Trigger mode encoding of edge_mode_i bits
   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_mode_e;

   // Identifier width: values 0..nsrc must fit (0 reserved for "none")
   function automatic int id_width(input int nsrc);
      return $clog2(nsrc + 1);
   endfunction

endpackage

// File: rtl/irq_id_decode.sv
module irq_id_decode #(
   parameter int NSRC = 8,
   parameter int IDW  = irq_gw_pkg::id_width(NSRC)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            valid_i,
   input  logic [IDW-1:0]  id_i,
   output logic [NSRC-1:0] hit_o
);

   for (genvar g = 0; g < NSRC; g++) begin : g_dec
      localparam logic [IDW-1:0] MyId = IDW'(g + 1);
      assign hit_o[g] = valid_i && (id_i == MyId);
   end

   // At most one source addressed by any event
   assert_single_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit_o));

   // Reserved or out-of-range identifiers address nothing
   assert_bad_id_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (int'(id_i) == 0 || int'(id_i) > NSRC)) |-> (hit_o == '0));

endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic src_i,
   input  logic edge_mode_i,
   output logic event_o
);
   import irq_gw_pkg::*;

   logic src_q;

   // Sample tracks the line every cycle, locked or not
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q <= 1'b0;
      else         src_q <= src_i;
   end

   always_comb begin
      if (trig_mode_e'(edge_mode_i) == TRIG_EDGE) event_o = src_i && !src_q;
      else                                       event_o = src_i;
   end

   // An edge event can never be reported while the previous sample is high
   assert_edge_needs_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i && event_o) |-> !src_q);

endmodule

// File: rtl/irq_gateway_cell.sv
module irq_gateway_cell (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic src_i,
   input  logic edge_mode_i,
   input  logic claim_hit_i,
   input  logic complete_hit_i,
   output logic pending_o,
   output logic in_service_o
);

   logic event_w;
   logic locked_w;
   logic take_w;
   logic free_w;
   logic pending_q;
   logic in_service_q;

   irq_trigger_detect u_detect (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_i       (src_i),
      .edge_mode_i (edge_mode_i),
      .event_o     (event_w)
   );

   assign locked_w = pending_q || in_service_q;
   assign take_w   = claim_hit_i && pending_q;
   assign free_w   = complete_hit_i && in_service_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pending_q    <= 1'b0;
         in_service_q <= 1'b0;
      end else begin
         if (take_w) begin
            pending_q    <= 1'b0;
            in_service_q <= 1'b1;
         end else if (free_w) begin
            in_service_q <= 1'b0;
         end else if (event_w && !locked_w) begin
            pending_q    <= 1'b1;
         end
      end
   end

   assign pending_o    = pending_q;
   assign in_service_o = in_service_q;

   assert_reset_clears_R1: assert property (@(posedge clk_i)
      !rst_ni |=> (!pending_q && !in_service_q));

   assert_claim_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_hit_i && pending_q) |=> (!pending_q && in_service_q));

   assert_claim_idle_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_hit_i && !pending_q && !in_service_q) |=> !in_service_q);

   assert_no_set_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_service_q |=> !$rose(pending_q));

   assert_complete_frees_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (complete_hit_i && in_service_q) |=> !in_service_q);

   assert_stray_complete_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (complete_hit_i && !in_service_q) |=> !in_service_q);

   assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pending_q && in_service_q));

endmodule

// File: rtl/irq_gateway_bank.sv
module irq_gateway_bank #(
   parameter int NSRC = 8,
   parameter int IDW  = irq_gw_pkg::id_width(NSRC)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] src_i,
   input  logic [NSRC-1:0] edge_mode_i,
   input  logic            claim_valid_i,
   input  logic [IDW-1:0]  claim_id_i,
   input  logic            complete_valid_i,
   input  logic [IDW-1:0]  complete_id_i,
   output logic [NSRC-1:0] pending_o,
   output logic [NSRC-1:0] in_service_o
);

   localparam int MinIdw = irq_gw_pkg::id_width(NSRC);

   if (NSRC < 1 || NSRC > 1023) begin : g_bad_nsrc
      $error("NSRC must lie in 1..1023");
   end
   if (IDW < MinIdw) begin : g_bad_idw
      $error("IDW too narrow for NSRC+1 identifiers");
   end

   logic [NSRC-1:0] claim_hit;
   logic [NSRC-1:0] complete_hit;

   irq_id_decode #(.NSRC(NSRC), .IDW(IDW)) u_claim_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (claim_valid_i),
      .id_i    (claim_id_i),
      .hit_o   (claim_hit)
   );

   irq_id_decode #(.NSRC(NSRC), .IDW(IDW)) u_complete_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (complete_valid_i),
      .id_i    (complete_id_i),
      .hit_o   (complete_hit)
   );

   for (genvar g = 0; g < NSRC; g++) begin : g_gw
      irq_gateway_cell u_cell (
         .clk_i          (clk_i),
         .rst_ni         (rst_ni),
         .src_i          (src_i[g]),
         .edge_mode_i    (edge_mode_i[g]),
         .claim_hit_i    (claim_hit[g]),
         .complete_hit_i (complete_hit[g]),
         .pending_o      (pending_o[g]),
         .in_service_o   (in_service_o[g])
      );
   end

   // A claim never raises more than one source into service per cycle
   assert_one_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(in_service_o & ~$past(in_service_o)) <= 1);

endmodule

// File: tb/tb_irq_gateway_bank.sv
module tb_irq_gateway_bank;
   localparam int NSRC = 8;
   localparam int IDW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src = '0;
   logic [NSRC-1:0] mode = 8'h0F;   // sources 0..3 edge, 4..7 level
   logic            cv = 1'b0;
   logic [IDW-1:0]  cid = '0;
   logic            dv = 1'b0;
   logic [IDW-1:0]  did = '0;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] insv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   irq_gateway_bank #(.NSRC(NSRC), .IDW(IDW)) dut (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .edge_mode_i(mode),
      .claim_valid_i(cv), .claim_id_i(cid),
      .complete_valid_i(dv), .complete_id_i(did),
      .pending_o(pend), .in_service_o(insv)
   );

   typedef struct packed {
      logic [7:0] s;
      logic       c_v;
      logic [3:0] c_id;
      logic       d_v;
      logic [3:0] d_id;
      logic [7:0] exp_p;
      logic [7:0] exp_s;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 8'h00, 8'h00, 4'd1}, // R1 idle after reset
      '{8'h01, 1'b0, 4'd0, 1'b0, 4'd0, 8'h01, 8'h00, 4'd2}, // R2 rising edge src0
      '{8'h01, 1'b0, 4'd0, 1'b0, 4'd0, 8'h01, 8'h00, 4'd2}, // R2 held high
      '{8'h01, 1'b1, 4'd1, 1'b0, 4'd0, 8'h00, 8'h01, 4'd4}, // R4 claim id1
      '{8'h00, 1'b0, 4'd0, 1'b0, 4'd0, 8'h00, 8'h01, 4'd5}, // R5 line falls
      '{8'h01, 1'b0, 4'd0, 1'b0, 4'd0, 8'h00, 8'h01, 4'd5}, // R5 edge while in service
      '{8'h01, 1'b0, 4'd0, 1'b1, 4'd1, 8'h00, 8'h00, 4'd6}, // R6 complete id1
      '{8'h01, 1'b0, 4'd0, 1'b0, 4'd0, 8'h00, 8'h00, 4'd7}, // R7 no stale edge
      '{8'h11, 1'b0, 4'd0, 1'b0, 4'd0, 8'h10, 8'h00, 4'd3}, // R3 level src4
      '{8'h11, 1'b1, 4'd5, 1'b0, 4'd0, 8'h00, 8'h10, 4'd4}, // R4 claim id5
      '{8'h11, 1'b0, 4'd0, 1'b1, 4'd5, 8'h00, 8'h00, 4'd6}, // R6 complete id5, still high
      '{8'h11, 1'b0, 4'd0, 1'b0, 4'd0, 8'h10, 8'h00, 4'd6}, // R6 level re-pends
      '{8'h11, 1'b1, 4'd0, 1'b0, 4'd0, 8'h10, 8'h00, 4'd8}, // R8 claim id0
      '{8'h11, 1'b1, 4'd9, 1'b0, 4'd0, 8'h10, 8'h00, 4'd8}, // R8 claim id9
      '{8'h11, 1'b0, 4'd0, 1'b1, 4'd5, 8'h10, 8'h00, 4'd8}, // R8 stray complete
      '{8'h11, 1'b1, 4'd2, 1'b0, 4'd0, 8'h10, 8'h00, 4'd4}, // R4 claim non-pending
      '{8'h13, 1'b1, 4'd5, 1'b0, 4'd0, 8'h02, 8'h10, 4'd2}, // R2 src1 edge + claim id5
      '{8'h11, 1'b1, 4'd2, 1'b0, 4'd0, 8'h00, 8'h12, 4'd4}, // R4 claim id2
      '{8'h13, 1'b0, 4'd0, 1'b0, 4'd0, 8'h00, 8'h12, 4'd5}, // R5 edge dropped
      '{8'h13, 1'b0, 4'd0, 1'b1, 4'd2, 8'h00, 8'h10, 4'd7}, // R7 complete id2, no replay
      '{8'h11, 1'b0, 4'd0, 1'b0, 4'd0, 8'h00, 8'h10, 4'd7}, // R7 line falls
      '{8'h13, 1'b0, 4'd0, 1'b0, 4'd0, 8'h02, 8'h10, 4'd2}  // R2 fresh edge accepted
   };

   task automatic check(input logic [7:0] ep, input logic [7:0] es, input int req);
      checks++;
      if (pend !== ep || insv !== es) begin
         errors++;
         $display("FAIL R%0d pending=%h in_service=%h expected pending=%h in_service=%h",
                  req, pend, insv, ep, es);
      end
      checks++;
      if ((pend & insv) !== 8'h00) begin   // R9
         errors++;
         $display("FAIL R9 overlap=%h expected 00", pend & insv);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(8'h00, 8'h00, 1);               // R1 during reset
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         src = VECS[i].s;
         cv  = VECS[i].c_v;  cid = VECS[i].c_id;
         dv  = VECS[i].d_v;  did = VECS[i].d_id;
         @(negedge clk);
         check(VECS[i].exp_p, VECS[i].exp_s, int'(VECS[i].req));
      end
      cv = 1'b0; dv = 1'b0; src = '0;
      // R1: reset in mid-operation clears pending and in-service
      rst_n = 1'b0;
      @(negedge clk);
      check(8'h00, 8'h00, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(8'h00, 8'h00, 1);
      // R3 after reset: level src7 pends, then claim id8 (highest valid id)
      src = 8'h80;
      @(negedge clk);
      check(8'h80, 8'h00, 3);
      cv = 1'b1; cid = 4'd8;
      @(negedge clk);
      check(8'h00, 8'h80, 4);
      cv = 1'b0;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule